// File: doc/BRIEF.md
# Prioritised Timing Source Selector

This block picks the clock reference that times the aggregate side of a sub-rate multiplexer. Three references are possible: the primary line port, the concatenation port toward a co-located unit, and a master clock made inside the block. A 2-bit mode field either fixes one of these references or asks for automatic selection. In automatic selection the line port has priority. The block fails over to the concatenation port when the line clock goes bad. It returns to the line port once the line clock has been good for a set number of consecutive cycles.

The internal master makes a one-cycle enable pulse at the rate chosen by a 2-bit speed field. It uses a fractional accumulator clocked by the system clock, so no divided clock is needed. Each change of the selection is registered and marked with a one-cycle event pulse. Alarms report a lost reference in a fixed mode, and the loss of both references in automatic mode.

Top module: `ts_select`

## Requirements
- R1: While rst_ni is low, sel_o is 0 (line port) and master_en_o, locked_o, ref_alarm_o, noref_alarm_o and sw_evt_o are all 0.
- R2: Mode 2'b00 sets sel_o to 0 (line), mode 2'b01 sets it to 1 (concatenation) and mode 2'b10 sets it to 2 (master). The new value shows on sel_o after the first rising clock edge at which the mode is present.
- R3: In mode 2'b00 or 2'b01, a bad indication for the fixed reference raises ref_alarm_o after the next edge and sel_o does not change. ref_alarm_o is 0 in every other case.
- R4: In mode 2'b11, while sel_o is 0, sel_o stays 0 as long as line_ok_i is high. If line_ok_i goes low while cat_ok_i is high, sel_o becomes 1 after the next edge.
- R5: In mode 2'b11, while sel_o is 1, sel_o returns to 0 only on the edge after line_ok_i has been sampled high on REVERT_CNT consecutive edges.
- R6: A low line_ok_i restarts the consecutive-good count. A broken streak does not bring about a revert.
- R7: In mode 2'b11, when both line_ok_i and cat_ok_i are low, sel_o keeps its value and noref_alarm_o is 1 after the next edge. In every other case noref_alarm_o is 0.
- R8: sw_evt_o is high for exactly the one cycle in which sel_o shows a new value, and low otherwise.
- R9: With sel_o at 2, master_en_o pulses exactly 64*(speed_i+1) times in every window of SYS_KHZ consecutive cycles. Speed code 00 means 64 kbit/s, 01 means 128, 10 means 192 and 11 means 256.
- R10: master_en_o never stays high for two cycles in a row. It is 0 whenever sel_o was not 2 on the previous cycle.
- R11: locked_o is 1 when the reference now selected was reported good at the edge that selected it. The master reference always counts as good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | 00 line, 01 concatenation, 10 master, 11 automatic |
| speed_i | input | 2 | Internal master rate, 64*(code+1) kbit/s |
| line_ok_i | input | 1 | Line port clock good |
| cat_ok_i | input | 1 | Concatenation port clock good |
| sel_o | output | 2 | Active reference: 0 line, 1 concatenation, 2 master |
| master_en_o | output | 1 | One-cycle enable pulse from the internal master |
| locked_o | output | 1 | Selected reference is good |
| ref_alarm_o | output | 1 | Fixed reference lost |
| noref_alarm_o | output | 1 | No good reference in automatic mode |
| sw_evt_o | output | 1 | Pulse on each selection change |

## Verification
The assertions assume that mode_i, speed_i and the two good flags are synchronous to clk_i and settle before each rising edge. The pulse-spacing check also assumes that SYS_KHZ is at least twice the top rate of 256. The bench changes every input on the falling edge only. It builds the bench with SYS_KHZ=1024, so one counting window of 1024 cycles holds a whole number of pulses. It changes speed_i only between counting windows, after a settling gap.

// File: rtl/ts_pkg.sv
package ts_pkg;
  typedef enum logic [1:0] {
    SRC_LINE   = 2'd0,
    SRC_CONCAT = 2'd1,
    SRC_MASTER = 2'd2
  } src_e;

  localparam logic [1:0] MODE_LINE   = 2'b00;
  localparam logic [1:0] MODE_CONCAT = 2'b01;
  localparam logic [1:0] MODE_MASTER = 2'b10;
  localparam logic [1:0] MODE_AUTO   = 2'b11;

  localparam int unsigned RATE_UNIT_KBPS = 64;
endpackage

// File: rtl/ts_revert_qual.sv
module ts_revert_qual #(
  parameter int unsigned REVERT_CNT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ok_i,
  output logic qual_o
);
  localparam int unsigned CNT_W = $clog2(REVERT_CNT + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(REVERT_CNT);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (!ok_i)          cnt_q <= '0;
    else if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign qual_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/ts_master_gen.sv
module ts_master_gen #(
  parameter int unsigned SYS_KHZ = 125000
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] speed_i,
  output logic       en_o
);
  import ts_pkg::*;
  localparam int unsigned ACC_W = $clog2(SYS_KHZ + 4 * RATE_UNIT_KBPS) + 1;
  localparam logic [ACC_W-1:0] MODULUS = ACC_W'(SYS_KHZ);

  logic [ACC_W-1:0] acc_q, inc, sum;
  logic             en_q;

  assign inc = ACC_W'((32'(speed_i) + 32'd1) * RATE_UNIT_KBPS);
  assign sum = acc_q + inc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      en_q  <= 1'b0;
    end else if (!run_i) begin
      acc_q <= '0;
      en_q  <= 1'b0;
    end else if (sum >= MODULUS) begin
      acc_q <= sum - MODULUS;
      en_q  <= 1'b1;
    end else begin
      acc_q <= sum;
      en_q  <= 1'b0;
    end
  end

  assign en_o = en_q;
endmodule

// File: rtl/ts_src_arbiter.sv
module ts_src_arbiter (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       line_ok_i,
  input  logic       cat_ok_i,
  input  logic       line_qual_i,
  output logic [1:0] sel_o,
  output logic       locked_o,
  output logic       ref_alarm_o,
  output logic       noref_alarm_o,
  output logic       sw_evt_o
);
  import ts_pkg::*;

  src_e sel_q, sel_nx;
  logic locked_q, ref_alarm_q, noref_q, sw_evt_q;

  always_comb begin
    sel_nx = sel_q;
    unique case (mode_i)
      MODE_LINE:   sel_nx = SRC_LINE;
      MODE_CONCAT: sel_nx = SRC_CONCAT;
      MODE_MASTER: sel_nx = SRC_MASTER;
      default: begin
        unique case (sel_q)
          SRC_LINE:   if (!line_ok_i && cat_ok_i) sel_nx = SRC_CONCAT;
          SRC_CONCAT: if (line_qual_i)            sel_nx = SRC_LINE;
          default: begin
            // leaving master: take best reference now present, else hold
            if (line_ok_i)     sel_nx = SRC_LINE;
            else if (cat_ok_i) sel_nx = SRC_CONCAT;
          end
        endcase
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q       <= SRC_LINE;
      locked_q    <= 1'b0;
      ref_alarm_q <= 1'b0;
      noref_q     <= 1'b0;
      sw_evt_q    <= 1'b0;
    end else begin
      sel_q       <= sel_nx;
      sw_evt_q    <= (sel_nx != sel_q);
      locked_q    <= (sel_nx == SRC_MASTER) ||
                     (sel_nx == SRC_LINE   && line_ok_i) ||
                     (sel_nx == SRC_CONCAT && cat_ok_i);
      ref_alarm_q <= (mode_i == MODE_LINE   && !line_ok_i) ||
                     (mode_i == MODE_CONCAT && !cat_ok_i);
      noref_q     <= (mode_i == MODE_AUTO) && !line_ok_i && !cat_ok_i;
    end
  end

  assign sel_o         = sel_q;
  assign locked_o      = locked_q;
  assign ref_alarm_o   = ref_alarm_q;
  assign noref_alarm_o = noref_q;
  assign sw_evt_o      = sw_evt_q;
endmodule

// File: rtl/ts_select.sv
module ts_select #(
  parameter int unsigned SYS_KHZ    = 125000,
  parameter int unsigned REVERT_CNT = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic [1:0] speed_i,
  input  logic       line_ok_i,
  input  logic       cat_ok_i,
  output logic [1:0] sel_o,
  output logic       master_en_o,
  output logic       locked_o,
  output logic       ref_alarm_o,
  output logic       noref_alarm_o,
  output logic       sw_evt_o
);
  import ts_pkg::*;

  logic line_qual;
  logic [1:0] sel;

  ts_revert_qual #(.REVERT_CNT(REVERT_CNT)) u_qual (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .ok_i  (line_ok_i),
    .qual_o(line_qual)
  );

  ts_src_arbiter u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .mode_i       (mode_i),
    .line_ok_i    (line_ok_i),
    .cat_ok_i     (cat_ok_i),
    .line_qual_i  (line_qual),
    .sel_o        (sel),
    .locked_o     (locked_o),
    .ref_alarm_o  (ref_alarm_o),
    .noref_alarm_o(noref_alarm_o),
    .sw_evt_o     (sw_evt_o)
  );

  ts_master_gen #(.SYS_KHZ(SYS_KHZ)) u_master (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (sel == SRC_MASTER),
    .speed_i(speed_i),
    .en_o   (master_en_o)
  );

  assign sel_o = sel;
endmodule

// File: rtl/ts_select_chk.sv
module ts_select_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] mode_i,
  input logic       line_ok_i,
  input logic       cat_ok_i,
  input logic [1:0] sel_o,
  input logic       master_en_o,
  input logic       ref_alarm_o,
  input logic       noref_alarm_o,
  input logic       sw_evt_o
);
  assert_reset_sel_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (sel_o == 2'd0 && !sw_evt_o && !master_en_o));

  assert_fixed_line_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b00 |=> sel_o == 2'd0);

  assert_fixed_master_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_i == 2'b10 |=> sel_o == 2'd2);

  assert_fixed_alarm_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b01 && !cat_ok_i) |=> (ref_alarm_o && sel_o == 2'd1));

  assert_auto_priority_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && sel_o == 2'd0 && line_ok_i) |=> sel_o == 2'd0);

  assert_noref_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b11 && !line_ok_i && !cat_ok_i) |=> (noref_alarm_o && $stable(sel_o)));

  assert_switch_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_evt_o == (sel_o != $past(sel_o)));

  assert_single_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_en_o |=> !master_en_o);

  assert_pulse_master_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    master_en_o |-> $past(sel_o) == 2'd2);
endmodule

bind ts_select ts_select_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .mode_i       (mode_i),
  .line_ok_i    (line_ok_i),
  .cat_ok_i     (cat_ok_i),
  .sel_o        (sel_o),
  .master_en_o  (master_en_o),
  .ref_alarm_o  (ref_alarm_o),
  .noref_alarm_o(noref_alarm_o),
  .sw_evt_o     (sw_evt_o)
);

// File: tb/ts_select_bench.sv
`timescale 1ns/1ps
module ts_select_bench;
  localparam int unsigned SYS_KHZ = 1024;
  localparam int unsigned REVERT  = 4;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] mode_i = 2'b11;
  logic [1:0] speed_i = 2'b00;
  logic       line_ok_i = 1'b0;
  logic       cat_ok_i = 1'b0;
  logic [1:0] sel_o;
  logic       master_en_o, locked_o, ref_alarm_o, noref_alarm_o, sw_evt_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ts_select #(.SYS_KHZ(SYS_KHZ), .REVERT_CNT(REVERT)) u_ts_select (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i), .speed_i(speed_i),
    .line_ok_i(line_ok_i), .cat_ok_i(cat_ok_i), .sel_o(sel_o),
    .master_en_o(master_en_o), .locked_o(locked_o), .ref_alarm_o(ref_alarm_o),
    .noref_alarm_o(noref_alarm_o), .sw_evt_o(sw_evt_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    step(2);
    chk("R1 sel", sel_o, 0);
    chk("R1 en", master_en_o, 0);
    chk("R1 locked", locked_o, 0);
    chk("R1 ref_alarm", ref_alarm_o, 0);
    chk("R1 noref", noref_alarm_o, 0);
    chk("R1 sw_evt", sw_evt_o, 0);
    rst_ni = 1'b1;
    step(1);
  endtask

  task automatic t_fixed;
    mode_i = 2'b00; line_ok_i = 1; cat_ok_i = 1; step(1);
    chk("R2 line sel", sel_o, 0);
    chk("R11 line locked", locked_o, 1);
    chk("R3 no alarm", ref_alarm_o, 0);
    mode_i = 2'b01; step(1);
    chk("R2 concat sel", sel_o, 1);
    chk("R8 evt on change", sw_evt_o, 1);
    step(1);
    chk("R8 evt one cycle", sw_evt_o, 0);
    cat_ok_i = 0; step(1);
    chk("R3 concat loss hold", sel_o, 1);
    chk("R3 concat loss alarm", ref_alarm_o, 1);
    chk("R11 unlocked", locked_o, 0);
    mode_i = 2'b00; line_ok_i = 0; cat_ok_i = 1; step(1);
    chk("R3 line loss hold", sel_o, 0);
    chk("R3 line loss alarm", ref_alarm_o, 1);
    mode_i = 2'b10; step(1);
    chk("R2 master sel", sel_o, 2);
    chk("R11 master locked", locked_o, 1);
    chk("R3 alarm cleared", ref_alarm_o, 0);
  endtask

  task automatic t_auto;
    mode_i = 2'b11; line_ok_i = 1; cat_ok_i = 1; step(1);
    chk("R4 auto picks line", sel_o, 0);
    step(3);
    chk("R4 line kept", sel_o, 0);
    chk("R8 quiet when stable", sw_evt_o, 0);
    line_ok_i = 0; step(1);
    chk("R4 failover", sel_o, 1);
    chk("R8 failover evt", sw_evt_o, 1);
  endtask

  task automatic t_revert;
    line_ok_i = 1; step(REVERT);
    chk("R5 not yet", sel_o, 1);
    step(1);
    chk("R5 reverted", sel_o, 0);
    chk("R8 revert evt", sw_evt_o, 1);
  endtask

  task automatic t_streak;
    line_ok_i = 0; step(1);
    chk("R4 failover again", sel_o, 1);
    line_ok_i = 1; step(REVERT - 1);
    line_ok_i = 0; step(1);
    chk("R6 broken streak", sel_o, 1);
    line_ok_i = 1; step(REVERT);
    chk("R6 count restarted", sel_o, 1);
    step(1);
    chk("R6 revert after full streak", sel_o, 0);
  endtask

  task automatic t_noref;
    line_ok_i = 0; cat_ok_i = 0; step(1);
    chk("R7 hold line", sel_o, 0);
    chk("R7 alarm", noref_alarm_o, 1);
    chk("R7 no evt", sw_evt_o, 0);
    cat_ok_i = 1; step(1);
    chk("R7 concat taken", sel_o, 1);
    chk("R7 alarm cleared", noref_alarm_o, 0);
    cat_ok_i = 0; step(2);
    chk("R7 hold concat", sel_o, 1);
    chk("R7 alarm again", noref_alarm_o, 1);
  endtask

  task automatic t_master;
    int cnt;
    int dbl;
    bit prev;
    mode_i = 2'b10;
    for (int s = 0; s < 4; s++) begin
      speed_i = 2'(s); step(8);
      cnt = 0; dbl = 0; prev = 0;
      for (int i = 0; i < int'(SYS_KHZ); i++) begin
        step(1);
        if (master_en_o) cnt++;
        if (master_en_o && prev) dbl++;
        prev = master_en_o;
      end
      chk("R9 pulse count", cnt, 64 * (s + 1));
      chk("R10 no back-to-back", dbl, 0);
    end
    mode_i = 2'b00; line_ok_i = 1; step(2);
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      step(1);
      if (master_en_o) cnt++;
    end
    chk("R10 silent outside master", cnt, 0);
  endtask

  initial begin
    t_reset;
    t_fixed;
    t_auto;
    t_revert;
    t_streak;
    t_noref;
    t_master;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule